// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is an 8-pin general-purpose I/O port with a programmable interrupt detector behind each pin. Software configures it through a small word-addressed register file. That file can be reached through two independent access ports, and both ports see identical offsets. Each pin has its own settings: edge or level detection, one edge or both edges, polarity, and a mask. The block keeps a raw status and a masked status, and it drives a single combined interrupt line.

Each pin input goes through a two-stage synchroniser. One more flop keeps the previous sample, and an edge is a difference between the current sample and that previous one. Edge events stay latched until software clears them. Level events are not latched and follow the pin. The port also holds output data, output-enable direction, digital-enable and alternate-select registers.

A parameter marks which pins are wired to a pad. A pin that is not wired ignores writes and reads back as 0.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `irq` is low, and `pinOe`, `pinOut` and `altSel` are 0.
- R2: A pin with sense=0 (offset 3), both=0 (offset 4), event=1 (offset 5) and den=1 (offset 2) sets its raw status bit (offset 7) on a rising input edge. It does not set on a falling edge.
- R3: With event=0 and the other settings as in R2, a pin sets its raw bit on a falling edge only.
- R4: With both=1, an edge-mode pin sets its raw bit on either edge, whatever its event bit.
- R5: A latched edge bit stays set until a 1 is written to that bit of the clear register (offset 9). Writing 0 there leaves it unchanged.
- R6: With sense=1, a pin's raw bit is 1 exactly while the synchronised pin equals its event bit. It is not latched.
- R7: Masked status (offset 8) equals raw status AND mask (offset 6). `irq` is the OR of the masked bits.
- R8: Bits outside `PRESENT_PINS` ignore writes and read back 0 in every register, and they never raise status.
- R9: A pin with den=0 raises no status. Its bit in the data register (offset 0) reads 0 while it is an input.
- R10: Port B reaches the same registers at the same offsets as port A. When both ports write the same register in one cycle, port A's value is kept.
- R11: `pinOut` equals the data register, and `pinOe` equals direction (offset 1) AND den. For pins with direction 1, the data register reads back the stored value; for other pins it reads the synchronised input. `altSel` equals the register at offset 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aWrEn | input | 1 | Port A write strobe |
| aAddr | input | 4 | Port A word offset |
| aWdata | input | 8 | Port A write data |
| aRdata | output | 8 | Port A read data (combinational) |
| bWrEn | input | 1 | Port B write strobe |
| bAddr | input | 4 | Port B word offset |
| bWdata | input | 8 | Port B write data |
| bRdata | output | 8 | Port B read data (combinational) |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output levels |
| pinOe | output | 8 | Pad output enables |
| altSel | output | 8 | Alternate-function select per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- latched edge bits survive any cycle that carries no clear or sense write;
- a newly latched bit always coincides with a change in the stored previous sample;
- pins with digital enable off or no pad never show raw status;
- a port A mask write always lands with A's data.

The directed scenarios are needed for the rest:
- the polarity and both-edge choices;
- level status that drops without a clear;
- the mask's effect on `irq`;
- the read-back mix of output data and input samples;
- port B access at the shared offsets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int NREG   = 11;

  localparam logic [ADDR_W-1:0] ADR_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_DEN   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_SENSE = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_BOTH  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EVENT = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_RAW   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_MSTAT = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_ALT   = 4'd10;

  // Write strobes from the control to the datapath, one bit per offset per port
  typedef struct packed {
    logic [NREG-1:0] wrA;
    logic [NREG-1:0] wrB;
  } bus_strobe_t;

  function automatic logic isStorage(input int idx);
    return !(idx == int'(ADR_RAW) || idx == int'(ADR_MSTAT) || idx == int'(ADR_CLR));
  endfunction
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     aWrEn,
  input  logic [ADDR_W-1:0]        aAddr,
  input  logic                     bWrEn,
  input  logic [ADDR_W-1:0]        bAddr,
  input  logic [NREG-1:0][W-1:0]   regView,
  output bus_strobe_t              strb,
  output logic [W-1:0]             aRdata,
  output logic [W-1:0]             bRdata
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < NREG; i++) begin
      strb.wrA[i] = aWrEn && (aAddr == ADDR_W'(i));
      strb.wrB[i] = bWrEn && (bAddr == ADDR_W'(i));
    end
  end

  always_comb begin
    aRdata = '0;
    bRdata = '0;
    if (int'(aAddr) < NREG) aRdata = regView[aAddr];
    if (int'(bAddr) < NREG) bRdata = regView[bAddr];
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int         W            = 8,
  parameter logic [W-1:0] PRESENT_PINS = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bus_strobe_t            strb,
  input  logic [W-1:0]           aWdata,
  input  logic [W-1:0]           bWdata,
  input  logic [W-1:0]           pinIn,
  output logic [NREG-1:0][W-1:0] regView,
  output logic [W-1:0]           pinOut,
  output logic [W-1:0]           pinOe,
  output logic [W-1:0]           altSel,
  output logic                   irq
);
  logic [W-1:0] cfgReg [NREG];
  logic [W-1:0] syncA, syncB, prevPin;
  logic [W-1:0] rawLatch, edgeSet, clrBits, levelHit, rawStatus, maskedStatus, dataRead;
  logic [W-1:0] riseHit, fallHit, edgeHit;

  // Register file: port A takes priority over port B on the same offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) cfgReg[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (isStorage(i)) begin
          if (strb.wrA[i])      cfgReg[i] <= aWdata & PRESENT_PINS;
          else if (strb.wrB[i]) cfgReg[i] <= bWdata & PRESENT_PINS;
        end
      end
    end
  end

  // Two-stage synchroniser plus previous-sample stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevPin <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevPin <= syncB;
    end
  end

  logic [W-1:0] senseR, bothR, eventR, denR, dirR, maskR;
  assign senseR = cfgReg[ADR_SENSE];
  assign bothR  = cfgReg[ADR_BOTH];
  assign eventR = cfgReg[ADR_EVENT];
  assign denR   = cfgReg[ADR_DEN];
  assign dirR   = cfgReg[ADR_DIR];
  assign maskR  = cfgReg[ADR_MASK];

  always_comb begin
    riseHit  = syncB & ~prevPin;
    fallHit  = ~syncB & prevPin;
    edgeHit  = (bothR & (riseHit | fallHit)) |
               (~bothR & ((eventR & riseHit) | (~eventR & fallHit)));
    edgeSet  = edgeHit & ~senseR & denR & PRESENT_PINS;
    levelHit = ~(syncB ^ eventR) & senseR & denR & PRESENT_PINS;
    clrBits  = (strb.wrA[ADR_CLR] ? aWdata : '0) | (strb.wrB[ADR_CLR] ? bWdata : '0);
  end

  // Edge events latch; a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawLatch <= '0;
    else       rawLatch <= ((rawLatch & ~clrBits) | edgeSet) & ~senseR & PRESENT_PINS;
  end

  always_comb begin
    rawStatus    = (rawLatch & ~senseR & denR) | levelHit;
    maskedStatus = rawStatus & maskR;
    dataRead     = ((cfgReg[ADR_DATA] & dirR) | (syncB & ~dirR & denR)) & PRESENT_PINS;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) regView[i] = cfgReg[i];
    regView[ADR_DATA]  = dataRead;
    regView[ADR_RAW]   = rawStatus;
    regView[ADR_MSTAT] = maskedStatus;
    regView[ADR_CLR]   = '0;
  end

  assign pinOut = cfgReg[ADR_DATA];
  assign pinOe  = dirR & denR;
  assign altSel = cfgReg[ADR_ALT];
  assign irq    = |maskedStatus;

  // Latched edge bits persist when no clear or sense write is in flight
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrA[ADR_CLR] && !strb.wrB[ADR_CLR] && !strb.wrA[ADR_SENSE] && !strb.wrB[ADR_SENSE])
    |=> ((rawLatch & $past(rawLatch)) == $past(rawLatch)));

  // A newly latched bit coincides with a change of the previous-sample stage
  assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawLatch & ~$past(rawLatch) & ~(prevPin ^ $past(prevPin))) == '0));

  // Digitally disabled pins raise no status
  assert_no_status_den_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus & ~denR) == '0));

  // Absent pins never show status or stored mask bits
  assert_absent_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (((rawStatus | maskR | rawLatch) & ~PRESENT_PINS) == '0));

  // Port A write to the mask always lands with A's data
  assert_port_a_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrA[ADR_MASK] |=> (maskR == ($past(aWdata) & PRESENT_PINS)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int           W            = 8,
  parameter logic [W-1:0] PRESENT_PINS = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aWrEn,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [W-1:0]      aWdata,
  output logic [W-1:0]      aRdata,
  input  logic              bWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [W-1:0]      bWdata,
  output logic [W-1:0]      bRdata,
  input  logic [W-1:0]      pinIn,
  output logic [W-1:0]      pinOut,
  output logic [W-1:0]      pinOe,
  output logic [W-1:0]      altSel,
  output logic              irq
);
  bus_strobe_t            strb;
  logic [NREG-1:0][W-1:0] regView;

  gpio_irq_ctrl #(.W(W)) u_ctrl (
    .aWrEn(aWrEn), .aAddr(aAddr), .bWrEn(bWrEn), .bAddr(bAddr),
    .regView(regView), .strb(strb), .aRdata(aRdata), .bRdata(bRdata)
  );

  gpio_irq_datapath #(.W(W), .PRESENT_PINS(PRESENT_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .aWdata(aWdata), .bWdata(bWdata),
    .pinIn(pinIn), .regView(regView), .pinOut(pinOut), .pinOe(pinOe),
    .altSel(altSel), .irq(irq)
  );
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 0, rstN = 0;
  logic       aWrEn = 0, bWrEn = 0;
  logic [3:0] aAddr = 0, bAddr = 0;
  logic [7:0] aWdata = 0, bWdata = 0, pinIn = 0;
  logic [7:0] aRdata, bRdata, pinOut, pinOe, altSel;
  logic       irq;
  int         nChecks = 0, nFails = 0;
  bit         finished = 0;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rstN(rstN), .aWrEn(aWrEn), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bWrEn(bWrEn), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .altSel(altSel), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrA(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); aWrEn = 1; aAddr = a; aWdata = d;
    @(negedge clk); aWrEn = 0;
  endtask

  task automatic wrB(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bWrEn = 1; bAddr = a; bWdata = d;
    @(negedge clk); bWrEn = 0;
  endtask

  task automatic rdA(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); aAddr = a; #1 d = aRdata;
  endtask

  task automatic rdB(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bAddr = a; #1 d = bRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] sense, input logic [7:0] both,
                       input logic [7:0] ev, input logic [7:0] mask);
    wrA(4'd2, 8'hFF); wrA(4'd3, sense); wrA(4'd4, both);
    wrA(4'd5, ev); wrA(4'd6, mask);
    settle(); wrA(4'd9, 8'hFF);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    for (int i = 0; i < 11; i++) begin
      rdA(4'(i), d); check("R1 reg read", d, 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 pinOut", pinOut, 8'h00);
    check("R1 altSel", altSel, 8'h00);
  endtask

  task automatic test_rise();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'h00, 8'h04, 8'h04);
    @(negedge clk); pinIn[2] = 1; settle();
    rdA(4'd7, d); check("R2 raw after rise", d, 8'h04);
    check("R2 irq after rise", {7'd0, irq}, 8'h01);
    wrA(4'd9, 8'h04);
    @(negedge clk); pinIn[2] = 0; settle();
    rdA(4'd7, d); check("R2 no set on fall", d, 8'h00);
  endtask

  task automatic test_fall();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'h00, 8'h00, 8'hFF);
    @(negedge clk); pinIn[5] = 1; settle();
    rdA(4'd7, d); check("R3 no set on rise", d, 8'h00);
    @(negedge clk); pinIn[5] = 0; settle();
    rdA(4'd7, d); check("R3 set on fall", d, 8'h20);
  endtask

  task automatic test_both();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'h08, 8'h00, 8'h00);
    @(negedge clk); pinIn[3] = 1; settle();
    rdA(4'd7, d); check("R4 rise with both", d, 8'h08);
    wrA(4'd9, 8'h08);
    @(negedge clk); pinIn[3] = 0; settle();
    rdA(4'd7, d); check("R4 fall with both", d, 8'h08);
  endtask

  task automatic test_clear();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'h00, 8'h03, 8'h00);
    @(negedge clk); pinIn[1:0] = 2'b11; settle();
    @(negedge clk); pinIn[1:0] = 2'b00; settle();
    rdA(4'd7, d); check("R5 latched after pin drops", d, 8'h03);
    wrA(4'd9, 8'h00); rdA(4'd7, d); check("R5 clear of 0 no effect", d, 8'h03);
    wrA(4'd9, 8'h01); rdA(4'd7, d); check("R5 clear bit0 only", d, 8'h02);
  endtask

  task automatic test_level();
    logic [7:0] d;
    pinIn = 0; setup(8'h01, 8'h00, 8'h01, 8'h01);
    @(negedge clk); pinIn[0] = 1; settle();
    rdA(4'd7, d); check("R6 level high active", d, 8'h01);
    check("R6 irq level", {7'd0, irq}, 8'h01);
    @(negedge clk); pinIn[0] = 0; settle();
    rdA(4'd7, d); check("R6 level not latched", d, 8'h00);
    wrA(4'd5, 8'h00); settle();
    rdA(4'd7, d); check("R6 low level active", d, 8'h01);
  endtask

  task automatic test_mask();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'h00, 8'h30, 8'h10);
    @(negedge clk); pinIn[5] = 1; settle();
    rdA(4'd7, d); check("R7 raw unmasked pin", d, 8'h20);
    rdA(4'd8, d); check("R7 masked status", d, 8'h00);
    check("R7 irq blocked", {7'd0, irq}, 8'h00);
    wrA(4'd6, 8'h20);
    rdA(4'd8, d); check("R7 masked after unmask", d, 8'h20);
    check("R7 irq passes", {7'd0, irq}, 8'h01);
    pinIn = 0;
  endtask

  task automatic test_absent();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'hFF, 8'hFF, 8'hFF);
    rdA(4'd6, d); check("R8 mask absent bit", d, 8'h7F);
    @(negedge clk); pinIn[7] = 1; settle();
    rdA(4'd7, d); check("R8 absent pin no status", d, 8'h00);
    check("R8 irq absent", {7'd0, irq}, 8'h00);
    rdA(4'd0, d); check("R8 data absent bit", d, 8'h00);
    pinIn = 0; settle();
  endtask

  task automatic test_den();
    logic [7:0] d;
    pinIn = 0; setup(8'h00, 8'hFF, 8'h00, 8'hFF);
    wrA(4'd2, 8'hFD); wrA(4'd9, 8'hFF);
    @(negedge clk); pinIn[1] = 1; settle();
    rdA(4'd7, d); check("R9 no status den off", d, 8'h00);
    check("R9 irq den off", {7'd0, irq}, 8'h00);
    rdA(4'd0, d); check("R9 data read den off", d, 8'h00);
    pinIn = 0; settle();
  endtask

  task automatic test_dual();
    logic [7:0] d;
    wrB(4'd6, 8'h0F);
    rdA(4'd6, d); check("R10 B write seen by A", d, 8'h0F);
    rdB(4'd6, d); check("R10 B read", d, 8'h0F);
    @(negedge clk); aWrEn = 1; aAddr = 4'd6; aWdata = 8'h33;
    bWrEn = 1; bAddr = 4'd6; bWdata = 8'h4C;
    @(negedge clk); aWrEn = 0; bWrEn = 0;
    rdB(4'd6, d); check("R10 A wins collision", d, 8'h33);
  endtask

  task automatic test_data();
    logic [7:0] d;
    wrA(4'd2, 8'hFF); wrA(4'd1, 8'h0F); wrB(4'd0, 8'hA5); wrA(4'd10, 8'h42);
    @(negedge clk); pinIn = 8'hF0; settle();
    check("R11 pinOut", pinOut, 8'h25);
    check("R11 pinOe", pinOe, 8'h0F);
    check("R11 altSel", altSel, 8'h42);
    rdA(4'd0, d); check("R11 data readback mix", d, 8'h75);
    wrA(4'd2, 8'h00);
    check("R11 pinOe den off", pinOe, 8'h00);
    pinIn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    test_reset(); test_rise(); test_fall(); test_both(); test_clear();
    test_level(); test_mask(); test_absent(); test_den(); test_dual(); test_data();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule